// File: doc/BRIEF.md
# Single-Phase Register Target for a 32-bit Parallel Bus

This block is the target side of a small memory-mapped register file on a conventional 32-bit multiplexed address/data bus with active-low framing strobes. It watches every address phase. When a memory read or memory write command lands inside its window, it claims the access with medium decode timing and moves exactly one DWord. The register space is non-prefetchable, so a read returns only the byte lanes the initiator enabled. A write changes only those lanes.

The target never takes more than one data phase. If the initiator keeps the frame strobe low to ask for more, the target raises its stop strobe together with its ready strobe on that first phase. After the transfer it holds the stop strobe until the frame strobe goes high. The target also disconnects on the first phase when the access asks for a non-linear burst order.

Register reads are answered directly from the register file. They do not wait on, or flush, any posted-write path. Unimplemented bits are never stored and always read as zero.

Top module: `csr_tgt_responder`

## Requirements
- R1: While reset is low, and after it, `devsel_n`, `trdy_n` and `stop_n` are high and `ad_oe` is low. Every register holds `RESET_VAL & IMPL_MASK` after reset.
- R2: Some commands claim the access: memory read `0110`, memory write `0111`, and, with `READ_ALIASES`=1, `1100` and `1110` as reads. Any of these, with address bits [31:5] equal to `BASE_ADDR`[31:5] (default window of 8 DWords), is claimed. `devsel_n` stays high in the clock right after the address phase and goes low in the clock after that.
- R3: During a read data phase, `ad_oe` is high and `ad_out` carries the addressed register for each lane `i` with `cbe_n[i]`=0. Disabled lanes are zero.
- R4: A write commits at the clock edge where `irdy_n` and `trdy_n` are both low. It replaces only the lanes whose `cbe_n` bit is 0; all other lanes and registers keep their values.
- R5: Bits that are 0 in `IMPL_MASK` (default: bit 31) are not stored and always read back as zero.
- R6: In a single-phase access (`frame_n` high at the edge after the address phase), `stop_n` stays high. In the clock after the transfer, `devsel_n` and `trdy_n` are high.
- R7: While `trdy_n` is low, `stop_n` is low exactly when `frame_n` was low at the previous edge, or when the access address has bits [1:0] other than `00`.
- R8: After a transfer with `frame_n` still low, `trdy_n` goes high while `stop_n` and `devsel_n` stay low until `frame_n` is seen high. No second DWord is read or written.
- R9: The target keeps `trdy_n` and `devsel_n` low through initiator wait states (`irdy_n` high). No write happens until `irdy_n` is low, and the data present at that edge is what gets written.
- R10: An access that is not claimed by R2 never asserts `devsel_n` or `trdy_n`, never drives `ad_oe`, and changes no register. Address bits [1:0] never affect hit or register selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Initiator frame strobe, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| ad_in | input | 32 | Address in the address phase, write data in data phases |
| ad_out | output | 32 | Read data, byte-masked |
| ad_oe | output | 1 | Target drives `ad_out` onto the bus |
| devsel_n | output | 1 | Target claims the access, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target requests termination, active low |

## Verification
The transfer of the single DWord and the disconnect request can fall in the same clock. This happens when the initiator keeps `frame_n` low through the first data phase, or asks for a non-linear order. The bench provokes this with burst reads and writes and with an address ending in `11`. It then checks that `trdy_n` and `stop_n` are low together in the transfer clock, that `trdy_n` alone rises in the next clock, and that the neighbouring register still holds its old value. Wait states overlap the claim with a delayed write. Those are judged by reading back the value present on the bus at the edge where `irdy_n` finally fell.

// File: rtl/csr_tgt_pkg.sv
package csr_tgt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DECODE,
      ST_DATA,
      ST_DISC,
      ST_MISS
   } tgt_state_e;

   localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
   localparam logic [3:0] CMD_MEM_WR      = 4'b0111;
   localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
   localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;

   localparam int LANES = 4;

   // expand active-low byte enables to a 32-bit lane mask
   function automatic logic [31:0] lane_mask(input logic [LANES-1:0] be_n);
      logic [31:0] m;
      for (int i = 0; i < LANES; i++) begin
         m[8*i +: 8] = {8{~be_n[i]}};
      end
      return m;
   endfunction

endpackage

// File: rtl/csr_tgt_decode.sv
module csr_tgt_decode
   import csr_tgt_pkg::*;
#(
   parameter logic [31:0] BASE_ADDR    = 32'h4000_1000,
   parameter int          NREG         = 8,
   parameter bit          READ_ALIASES = 1'b1,
   localparam int         IDXW         = $clog2(NREG),
   localparam int         WIN_LSB      = 2 + IDXW
) (
   input  logic [31:0]     addr,
   input  logic [3:0]      cmd,
   output logic            hit,
   output logic            is_write,
   output logic            order_ok,
   output logic [IDXW-1:0] idx
);

   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two and at least 2");
   end
   if (BASE_ADDR[WIN_LSB-1:0] != '0) begin : g_bad_base
      $error("BASE_ADDR must be aligned to the window size");
   end

   logic is_read;

   if (READ_ALIASES) begin : g_rd_alias
      assign is_read = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_RD_MULT) ||
                       (cmd == CMD_MEM_RD_LINE);
   end else begin : g_rd_plain
      assign is_read = (cmd == CMD_MEM_RD);
   end

   assign is_write = (cmd == CMD_MEM_WR);
   assign hit      = (is_read || is_write) &&
                     (addr[31:WIN_LSB] == BASE_ADDR[31:WIN_LSB]);
   assign idx      = addr[WIN_LSB-1:2];
   // only linear burst order is accepted without an early disconnect
   assign order_ok = (addr[1:0] == 2'b00);

endmodule

// File: rtl/csr_tgt_fsm.sv
module csr_tgt_fsm
   import csr_tgt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_n,
   input  logic       irdy_n,
   input  logic       hit,
   input  logic       order_ok,
   output tgt_state_e state,
   output logic       addr_strobe,
   output logic       xfer,
   output logic       devsel_n,
   output logic       trdy_n,
   output logic       stop_n
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         devsel_n <= 1'b1;
         trdy_n   <= 1'b1;
         stop_n   <= 1'b1;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (!frame_n) state <= ST_DECODE;
            end
            ST_DECODE: begin
               if (hit) begin
                  state    <= ST_DATA;
                  devsel_n <= 1'b0;
                  trdy_n   <= 1'b0;
                  stop_n   <= frame_n & order_ok;
               end else begin
                  state <= ST_MISS;
               end
            end
            ST_DATA: begin
               if (!irdy_n) begin
                  trdy_n <= 1'b1;
                  if (!frame_n) begin
                     state  <= ST_DISC;
                     stop_n <= 1'b0;
                  end else begin
                     state    <= ST_IDLE;
                     devsel_n <= 1'b1;
                     stop_n   <= 1'b1;
                  end
               end else begin
                  stop_n <= frame_n & order_ok;
               end
            end
            ST_DISC: begin
               if (frame_n) begin
                  state    <= ST_IDLE;
                  devsel_n <= 1'b1;
                  stop_n   <= 1'b1;
               end
            end
            ST_MISS: begin
               if (frame_n && irdy_n) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign addr_strobe = (state == ST_IDLE) && !frame_n;
   assign xfer        = (state == ST_DATA) && !irdy_n;

   assert_ready_needs_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !trdy_n |-> !devsel_n);

   assert_medium_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(devsel_n) |-> $past(state == ST_DECODE));

   assert_one_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> trdy_n);

   assert_stop_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!trdy_n && !stop_n) |-> ($past(!frame_n) || $past(!order_ok)));

   assert_disc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DISC) |-> (trdy_n && !stop_n && !devsel_n));

   assert_no_claim_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MISS) |-> (devsel_n && trdy_n));

endmodule

// File: rtl/csr_tgt_regfile.sv
module csr_tgt_regfile
   import csr_tgt_pkg::*;
#(
   parameter int          NREG      = 8,
   parameter logic [31:0] IMPL_MASK = 32'h7FFF_FFFF,
   parameter logic [31:0] RESET_VAL = 32'hFFFF_0000,
   localparam int         IDXW      = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDXW-1:0]  widx,
   input  logic [LANES-1:0] wbe_n,
   input  logic [31:0]      wdata,
   input  logic [IDXW-1:0]  ridx,
   output logic [31:0]      rdata
);

   logic [NREG-1:0][31:0] regs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NREG; r++) begin
            regs[r] <= RESET_VAL & IMPL_MASK;
         end
      end else if (we) begin
         for (int l = 0; l < LANES; l++) begin
            if (!wbe_n[l]) begin
               regs[widx][8*l +: 8] <= wdata[8*l +: 8] & IMPL_MASK[8*l +: 8];
            end
         end
      end
   end

   assign rdata = regs[ridx];

   for (genvar r = 0; r < NREG; r++) begin : g_reg_chk
      for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
         assert_lane_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && (widx == r[IDXW-1:0]) && !wbe_n[l]) |=> $stable(regs[r][8*l +: 8]));
      end
   end

   assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & ~IMPL_MASK) == 32'h0);

endmodule

// File: rtl/csr_tgt_responder.sv
module csr_tgt_responder
   import csr_tgt_pkg::*;
#(
   parameter logic [31:0] BASE_ADDR    = 32'h4000_1000,
   parameter int          NREG         = 8,
   parameter logic [31:0] IMPL_MASK    = 32'h7FFF_FFFF,
   parameter logic [31:0] RESET_VAL    = 32'hFFFF_0000,
   parameter bit          READ_ALIASES = 1'b1,
   localparam int         IDXW         = $clog2(NREG)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        frame_n,
   input  logic        irdy_n,
   input  logic [3:0]  cbe_n,
   input  logic [31:0] ad_in,
   output logic [31:0] ad_out,
   output logic        ad_oe,
   output logic        devsel_n,
   output logic        trdy_n,
   output logic        stop_n
);

   tgt_state_e      state;
   logic            addr_strobe;
   logic            xfer;
   logic [31:0]     addr_q;
   logic [3:0]      cmd_q;
   logic            hit;
   logic            is_write;
   logic            order_ok;
   logic [IDXW-1:0] idx;
   logic [31:0]     rd_word;

   // address phase capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cmd_q  <= '0;
      end else if (addr_strobe) begin
         addr_q <= ad_in;
         cmd_q  <= cbe_n;
      end
   end

   csr_tgt_decode #(
      .BASE_ADDR   (BASE_ADDR),
      .NREG        (NREG),
      .READ_ALIASES(READ_ALIASES)
   ) u_decode (
      .addr    (addr_q),
      .cmd     (cmd_q),
      .hit     (hit),
      .is_write(is_write),
      .order_ok(order_ok),
      .idx     (idx)
   );

   csr_tgt_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_n    (frame_n),
      .irdy_n     (irdy_n),
      .hit        (hit),
      .order_ok   (order_ok),
      .state      (state),
      .addr_strobe(addr_strobe),
      .xfer       (xfer),
      .devsel_n   (devsel_n),
      .trdy_n     (trdy_n),
      .stop_n     (stop_n)
   );

   csr_tgt_regfile #(
      .NREG     (NREG),
      .IMPL_MASK(IMPL_MASK),
      .RESET_VAL(RESET_VAL)
   ) u_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (xfer && is_write),
      .widx (idx),
      .wbe_n(cbe_n),
      .wdata(ad_in),
      .ridx (idx),
      .rdata(rd_word)
   );

   assign ad_oe  = (state == ST_DATA) && !is_write;
   assign ad_out = ad_oe ? (rd_word & lane_mask(cbe_n)) : 32'h0;

   assert_drive_in_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> (!trdy_n && !devsel_n));

   assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ad_oe |-> (ad_out == 32'h0));

endmodule

// File: tb/csr_tgt_responder_tb.sv
module csr_tgt_responder_tb;

   localparam logic [31:0] BASE = 32'h4000_1000;
   localparam int          NREG = 8;
   localparam logic [31:0] IMPL = 32'h7FFF_FFFF;
   localparam logic [31:0] RVAL = 32'hFFFF_0000;

   localparam logic [3:0] C_RD  = 4'b0110;
   localparam logic [3:0] C_WR  = 4'b0111;
   localparam logic [3:0] C_RDM = 4'b1100;
   localparam logic [3:0] C_CFG = 4'b1010;
   localparam logic [3:0] C_IOW = 4'b0011;

   // {burst, cmd, addr, be_n, wdata}
   localparam int NV = 16;
   localparam logic [72:0] VEC [NV] = '{
      {1'b0, C_WR,  32'h4000_1000, 4'b0000, 32'h8765_4321},
      {1'b0, C_RD,  32'h4000_1000, 4'b0000, 32'h0},
      {1'b0, C_WR,  32'h4000_1004, 4'b1010, 32'hAABB_CCDD},
      {1'b0, C_RD,  32'h4000_1004, 4'b0000, 32'h0},
      {1'b0, C_RD,  32'h4000_1000, 4'b0101, 32'h0},
      {1'b1, C_WR,  32'h4000_1010, 4'b0000, 32'h1234_5678},
      {1'b0, C_RD,  32'h4000_1013, 4'b0000, 32'h0},
      {1'b0, C_RD,  32'h4000_1014, 4'b0000, 32'h0},
      {1'b0, C_RD,  32'h4000_1020, 4'b0000, 32'h0},
      {1'b0, C_WR,  32'h4000_0FFC, 4'b0000, 32'hDEAD_BEEF},
      {1'b0, C_CFG, 32'h4000_1000, 4'b0000, 32'h0},
      {1'b1, C_RDM, 32'h4000_1004, 4'b0000, 32'h0},
      {1'b0, C_WR,  32'h4000_1008, 4'b0000, 32'hFFFF_FFFF},
      {1'b0, C_RD,  32'h4000_1008, 4'b0011, 32'h0},
      {1'b0, C_IOW, 32'h4000_1000, 4'b0000, 32'h5555_5555},
      {1'b0, C_RD,  32'h4000_1000, 4'b0000, 32'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic        irdy_n = 1'b1;
   logic [3:0]  cbe_n = 4'hF;
   logic [31:0] ad_in = 32'h0;
   logic [31:0] ad_out;
   logic        ad_oe;
   logic        devsel_n;
   logic        trdy_n;
   logic        stop_n;

   always #4 clk = ~clk;

   csr_tgt_responder #(
      .BASE_ADDR(BASE),
      .NREG     (NREG),
      .IMPL_MASK(IMPL),
      .RESET_VAL(RVAL)
   ) u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .frame_n (frame_n),
      .irdy_n  (irdy_n),
      .cbe_n   (cbe_n),
      .ad_in   (ad_in),
      .ad_out  (ad_out),
      .ad_oe   (ad_oe),
      .devsel_n(devsel_n),
      .trdy_n  (trdy_n),
      .stop_n  (stop_n)
   );

   int          n_chk = 0;
   int          n_bad = 0;
   logic [31:0] mdl [NREG];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] bmask(input logic [3:0] be_n);
      logic [31:0] m;
      for (int i = 0; i < 4; i++) m[8*i +: 8] = be_n[i] ? 8'h00 : 8'hFF;
      return m;
   endfunction

   function automatic bit claims(input logic [3:0] cmd, input logic [31:0] a);
      bit cmd_ok = (cmd == C_RD) || (cmd == C_WR) || (cmd == C_RDM) || (cmd == 4'b1110);
      return cmd_ok && (a[31:5] == BASE[31:5]);
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NREG; i++) mdl[i] = RVAL & IMPL;
   endtask

   task automatic check_idle(input string req, input string what);
      chk(devsel_n && trdy_n && stop_n && !ad_oe, req, what,
          {28'h0, devsel_n, trdy_n, stop_n, ad_oe}, 32'hE);
   endtask

   task automatic run_acc(input logic [3:0] cmd, input logic [31:0] a,
                          input logic [3:0] be, input logic [31:0] wd,
                          input bit burst, input int waits);
      int  ix   = int'(a[4:2]);
      bit  wr   = (cmd == C_WR);
      bit  h    = claims(cmd, a);
      bit  xstp = burst || (waits > 0) || (a[1:0] != 2'b00);
      logic [31:0] exp_rd;
      // address phase
      @(posedge clk); #1;
      frame_n = 1'b0; irdy_n = 1'b1; ad_in = a; cbe_n = cmd;
      @(posedge clk); #1;
      cbe_n = be;
      if (waits > 0) begin
         frame_n = 1'b0; irdy_n = 1'b1; ad_in = ~wd;
      end else begin
         frame_n = !burst; irdy_n = 1'b0; ad_in = wr ? wd : 32'h0;
      end
      if (!h) begin
         for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check_idle("R10", "unclaimed access drove the bus");
            chk(ad_out == 32'h0, "R10", "ad_out on miss", ad_out, 32'h0);
         end
         @(posedge clk); #1;
         frame_n = 1'b1; irdy_n = 1'b1;
         @(posedge clk); #1;
         return;
      end
      @(negedge clk);
      chk(devsel_n == 1'b1, "R2", "devsel before medium slot", {31'h0, devsel_n}, 32'h1);
      for (int w = 0; w < waits; w++) begin
         @(negedge clk);
         chk(!trdy_n && !devsel_n, "R9", "ready held in wait state",
             {30'h0, devsel_n, trdy_n}, 32'h0);
         @(posedge clk); #1;
         if (w == waits - 1) begin
            frame_n = !burst; irdy_n = 1'b0; ad_in = wd;
         end
      end
      // transfer cycle
      @(negedge clk);
      chk(!devsel_n && !trdy_n, "R2", "claim in data phase",
          {30'h0, devsel_n, trdy_n}, 32'h0);
      chk(stop_n == !xstp, "R7", "stop with first phase", {31'h0, stop_n}, {31'h0, !xstp});
      if (wr) begin
         chk(!ad_oe, "R3", "ad_oe during write", {31'h0, ad_oe}, 32'h0);
      end else begin
         exp_rd = mdl[ix] & bmask(be);
         chk(ad_oe, "R3", "ad_oe during read", {31'h0, ad_oe}, 32'h1);
         chk(ad_out == exp_rd, "R3", "read data lanes", ad_out, exp_rd);
      end
      @(posedge clk); #1;
      if (wr) mdl[ix] = (mdl[ix] & ~bmask(be)) | (wd & bmask(be) & IMPL);
      if (burst) begin
         frame_n = 1'b1; irdy_n = 1'b0; ad_in = ~wd;
         @(negedge clk);
         chk(trdy_n && !stop_n && !devsel_n, "R8", "disconnect hold",
             {29'h0, devsel_n, trdy_n, stop_n}, 32'h2);
         @(posedge clk); #1;
         irdy_n = 1'b1;
         @(negedge clk);
         check_idle("R8", "release after disconnect");
      end else begin
         irdy_n = 1'b1;
         @(negedge clk);
         check_idle("R6", "release after single phase");
      end
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      check_idle("R1", "outputs during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1", "outputs after reset");

      // vector table
      for (int v = 0; v < NV; v++) begin
         logic        vb;
         logic [3:0]  vc;
         logic [31:0] va;
         logic [3:0]  ve;
         logic [31:0] vd;
         {vb, vc, va, ve, vd} = VEC[v];
         run_acc(vc, va, ve, vd, vb, 0);
      end

      // R9: write with two initiator wait states, junk data during the wait
      run_acc(C_WR, 32'h4000_1018, 4'b0000, 32'h0000_2222, 1'b0, 2);
      run_acc(C_RD, 32'h4000_1018, 4'b0000, 32'h0, 1'b0, 0);

      // R8: burst write must not touch the next register
      run_acc(C_WR, 32'h4000_100C, 4'b0000, 32'h0BAD_F00D, 1'b1, 0);
      run_acc(C_RD, 32'h4000_1010, 4'b0000, 32'h0, 1'b0, 0);
      run_acc(C_RD, 32'h4000_100C, 4'b0000, 32'h0, 1'b0, 0);

      // R1: reset restores register contents
      @(posedge clk); #1;
      rst_n = 1'b0;
      @(negedge clk);
      check_idle("R1", "outputs in second reset");
      @(posedge clk); #1;
      rst_n = 1'b1;
      model_reset();
      run_acc(C_RD, 32'h4000_1000, 4'b0000, 32'h0, 1'b0, 0);
      run_acc(C_RD, 32'h4000_1008, 4'b0000, 32'h0, 1'b0, 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(8 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule